// File: doc/BRIEF.md
# Frobenius-Class Minimum Rotation Selector

This block takes a curve point whose two coordinates are m-bit words in normal-basis form. It replaces the point with one fixed member of its Frobenius equivalence class. In normal basis, squaring a coordinate is a cyclic shift of its bits. All m class members can therefore be formed from x by wiring alone, with no squaring logic. The block reads each rotation of x as an unsigned number and compares only a truncated field of its top bits. A pipelined binary tree of comparators picks the smallest rotation. The block then applies the same rotation to both x and y.

The point is fed as a word pair with a valid flag, and a new point may arrive every cycle. Each result comes out a fixed number of cycles later. It carries the rotated x, the rotated y and the chosen rotation amount. Ties on the truncated field go to the lower rotation index, so the same class always maps to the same output. Both the word width m and the compare width t are parameters. A small instance can therefore be swept in full against a straightforward scan.

Top module: `frob_class_min`

## Requirements
- R1: While `rst` is high, and on the first edges after it, `out_valid`, `out_x`, `out_y` and `out_rot` are all zero, whatever the inputs are.
- R2: A word pair accepted with `in_valid` high on a clock edge produces `out_valid` high exactly ceil(log2(M))+1 edges later.
- R3: `out_rot` is the amount r in 0..M-1 that makes the top T bits of rot(in_x, r) the smallest unsigned value. Here rot(v, r) moves bit j of v to bit (j+r) mod M, a left rotation.
- R4: When several amounts tie on the top T bits, the smallest such r is reported.
- R5: `out_x` equals rot(in_x, out_rot).
- R6: `out_y` equals rot(in_y, out_rot), using the same rotation as x.
- R7: Inputs may arrive on every cycle or with any pattern of gaps. Each accepted pair gives exactly one result, in arrival order, and no result appears without an input.
- R8: The compare uses only the top T bits of each rotation. Rotations that differ only in their low M-T bits count as equal and fall to R4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input pair present this cycle |
| in_x | input | M | x coordinate, normal basis |
| in_y | input | M | y coordinate, normal basis |
| out_valid | output | 1 | Result present this cycle |
| out_x | output | M | x rotated to the class minimum |
| out_y | output | M | y rotated by the same amount |
| out_rot | output | ceil(log2(M)) | Chosen rotation amount |

## Verification
Two things can land on the same output cycle. One is the choice among candidates whose truncated keys tie. The other is the rotation of x and y by that choice. A candidate that wins on the key but is rotated wrongly, or rotated by the wrong lane's amount, shows up only when both happen together. The bench makes ties frequent with an instance where T is smaller than M, and makes them rare with a second instance where T equals M. Every x value is streamed back to back, then in gapped bursts. Each result is judged against a linear scan that keeps the first strict minimum, and against rotations computed arithmetically, in the exact cycle the latency predicts.

// File: rtl/frob_pkg.sv
package frob_pkg;

    // Default field width and compare width for the full-size instance.
    localparam int unsigned FROB_M_DEF = 113;
    localparam int unsigned FROB_T_DEF = 70;

    // Number of registered comparator levels needed to reduce n leaves.
    function automatic int unsigned tree_levels(input int unsigned n);
        int unsigned lv;
        lv = 0;
        while ((1 << lv) < n) lv++;
        return lv;
    endfunction

endpackage

// File: rtl/frob_cand_gen.sv
module frob_cand_gen #(
    parameter int unsigned M = 113,
    parameter int unsigned T = 70,
    parameter int unsigned N = 128
) (
    input  logic [M-1:0] x,
    output logic [T-1:0] keys [N]
);
    // Candidate i is x rotated left by i; its key is the top T bits.
    for (genvar i = 0; i < N; i++) begin : g_cand
        if (i < M) begin : g_live
            logic [M-1:0] rot;
            assign rot     = (x << i) | (x >> (M - i));
            assign keys[i] = rot[M-1 -: T];
        end else begin : g_pad
            assign keys[i] = '0;
        end
    end
endmodule

// File: rtl/frob_min_tree.sv
module frob_min_tree #(
    parameter int unsigned M  = 113,
    parameter int unsigned T  = 70,
    parameter int unsigned L  = 7,
    parameter int unsigned N  = 128,
    parameter int unsigned IW = 7
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [T-1:0]  keys [N],
    output logic [IW-1:0] win_idx
);
    typedef struct packed {
        logic          ok;
        logic [T-1:0]  key;
        logic [IW-1:0] idx;
    } cand_t;

    // Left operand always holds lower indices, so "<=" keeps the lower one.
    function automatic cand_t pick(input cand_t a, input cand_t b);
        if (a.ok && (!b.ok || a.key <= b.key)) return a;
        return b;
    endfunction

    cand_t node [1:N-1];   // registered internal nodes, heap order
    cand_t kid  [2:2*N-1]; // children view: leaves above N, nodes below

    always_comb begin
        for (int j = 2; j < 2 * N; j++) begin
            if (j >= N) begin
                kid[j].ok  = ((j - N) < M);
                kid[j].key = keys[j-N];
                kid[j].idx = IW'(j - N);
            end else begin
                kid[j] = node[j];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int k = 1; k < N; k++) node[k] <= '0;
        end else begin
            for (int k = 1; k < N; k++) node[k] <= pick(kid[2*k], kid[2*k+1]);
        end
    end

    assign win_idx = node[1].idx;

    // R3
    win_range_chk: assert property (@(posedge clk) disable iff (rst)
        node[1].ok |-> (node[1].idx < IW'(M)));

    // R4: tie at the root resolves toward the left (lower) subtree
    tie_left_chk: assert property (@(posedge clk) disable iff (rst)
        (node[2].ok && node[3].ok && node[2].key == node[3].key)
        |=> (node[1].idx == $past(node[2].idx)));
endmodule

// File: rtl/frob_delay.sv
module frob_delay #(
    parameter int unsigned W = 8,
    parameter int unsigned D = 1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] stage [D+1];
    assign stage[0] = din;

    for (genvar s = 0; s < D; s++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) stage[s+1] <= '0;
            else     stage[s+1] <= stage[s];
        end
    end

    assign dout = stage[D];
endmodule

// File: rtl/frob_rotator.sv
module frob_rotator #(
    parameter int unsigned M  = 113,
    parameter int unsigned IW = 7
) (
    input  logic [M-1:0]  din,
    input  logic [IW-1:0] amt,
    output logic [M-1:0]  dout
);
    logic [M-1:0] st [IW+1];
    assign st[0] = din;

    // Stage s rotates by 2^s mod M when bit s of the amount is set.
    for (genvar s = 0; s < IW; s++) begin : g_bar
        localparam int unsigned SH = (1 << s) % M;
        logic [M-1:0] rot;
        assign rot     = (st[s] << SH) | (st[s] >> (M - SH));
        assign st[s+1] = amt[s] ? rot : st[s];
    end

    assign dout = st[IW];
endmodule

// File: rtl/frob_class_min.sv
module frob_class_min
    import frob_pkg::*;
#(
    parameter int unsigned M = FROB_M_DEF,
    parameter int unsigned T = FROB_T_DEF,
    localparam int unsigned L  = tree_levels(M),
    localparam int unsigned N  = 1 << L,
    localparam int unsigned IW = L
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          in_valid,
    input  logic [M-1:0]  in_x,
    input  logic [M-1:0]  in_y,
    output logic          out_valid,
    output logic [M-1:0]  out_x,
    output logic [M-1:0]  out_y,
    output logic [IW-1:0] out_rot
);
    logic [T-1:0]  keys [N];
    logic [IW-1:0] win_idx;
    logic [2*M:0]  dly_out;
    logic          vd;
    logic [M-1:0]  xd, yd, rx, ry;

    frob_cand_gen #(.M(M), .T(T), .N(N)) u_cand (
        .x(in_x), .keys(keys)
    );

    frob_min_tree #(.M(M), .T(T), .L(L), .N(N), .IW(IW)) u_tree (
        .clk(clk), .rst(rst), .keys(keys), .win_idx(win_idx)
    );

    frob_delay #(.W(2*M+1), .D(L)) u_dly (
        .clk(clk), .rst(rst), .din({in_valid, in_x, in_y}), .dout(dly_out)
    );
    assign {vd, xd, yd} = dly_out;

    frob_rotator #(.M(M), .IW(IW)) u_rot_x (.din(xd), .amt(win_idx), .dout(rx));
    frob_rotator #(.M(M), .IW(IW)) u_rot_y (.din(yd), .amt(win_idx), .dout(ry));

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_x     <= '0;
            out_y     <= '0;
            out_rot   <= '0;
        end else begin
            out_valid <= vd;
            out_x     <= rx;
            out_y     <= ry;
            out_rot   <= win_idx;
        end
    end

    // Neighbour rotations of the result, used only by the checks below.
    logic [M-1:0] nb_up, nb_dn;
    assign nb_up = {out_x[M-2:0], out_x[M-1]};
    assign nb_dn = {out_x[0], out_x[M-1:1]};

    // R3
    rot_range_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (out_rot < IW'(M)));

    // R3 R8
    min_up_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (out_x[M-1 -: T] <= nb_up[M-1 -: T]));

    // R3 R8
    min_dn_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (out_x[M-1 -: T] <= nb_dn[M-1 -: T]));

    // R5
    weight_x_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> ($countones(out_x) == $countones($past(xd))));

    // R6
    weight_y_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> ($countones(out_y) == $countones($past(yd))));
endmodule

// File: tb/tb_frob_class_min.sv
module tb_frob_lane #(
    parameter int M = 5,
    parameter int T = 3
) (
    input  logic clk,
    input  logic rst,
    output logic done,
    output int   checks,
    output int   fails
);
    localparam int L   = $clog2(M);
    localparam int LAT = L + 1;
    localparam int IW  = L;
    localparam int MASK = (1 << M) - 1;

    logic          in_valid;
    logic [M-1:0]  in_x, in_y;
    logic          out_valid;
    logic [M-1:0]  out_x, out_y;
    logic [IW-1:0] out_rot;

    frob_class_min #(.M(M), .T(T)) dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_x(in_x), .in_y(in_y),
        .out_valid(out_valid), .out_x(out_x), .out_y(out_y), .out_rot(out_rot)
    );

    typedef struct {
        int due;
        int x;
        int y;
        int r;
        bit tie;
    } exp_t;

    exp_t q[$];
    int   cyc = 0;
    bit   live = 0;

    always @(posedge clk) cyc <= cyc + 1;

    function automatic int rotl(input int v, input int r);
        return ((v << r) | (v >> (M - r))) & MASK;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s (M=%0d T=%0d) actual=%0d expected=%0d at cycle %0d",
                     req, M, T, act, exp, cyc);
        end
    endtask

    task automatic send(input bit v, input int x, input int y);
        exp_t e;
        int best, key, cnt;
        @(posedge clk);
        #1;
        in_valid = v;
        in_x     = M'(x);
        in_y     = M'(y);
        if (v) begin
            best = 1 << T;
            e.r  = 0;
            cnt  = 0;
            for (int r = 0; r < M; r++) begin
                key = rotl(x, r) >> (M - T);
                if (key < best) begin best = key; e.r = r; end
            end
            for (int r = 0; r < M; r++)
                if ((rotl(x, r) >> (M - T)) == best) cnt++;
            e.due = cyc + LAT;
            e.x   = x;
            e.y   = y;
            e.tie = (cnt > 1);
            q.push_back(e);
        end
    endtask

    // Monitor: samples on the falling edge, away from the active edge.
    always @(negedge clk) begin
        if (live) begin
            bit want;
            exp_t e;
            want = (q.size() > 0) && (q[0].due == cyc);
            // R2 R7: valid in exactly the predicted cycle, never otherwise
            check(out_valid == want, "R2/R7 out_valid timing", int'(out_valid), int'(want));
            if (out_valid && want) begin
                e = q.pop_front();
                if (e.tie) check(int'(out_rot) == e.r, "R4 tie to lowest rotation", int'(out_rot), e.r);
                else       check(int'(out_rot) == e.r, "R3 minimum rotation", int'(out_rot), e.r);
                check(int'(out_x) == rotl(e.x, e.r), "R5 rotated x", int'(out_x), rotl(e.x, e.r));
                check(int'(out_y) == rotl(e.y, e.r), "R6 rotated y", int'(out_y), rotl(e.y, e.r));
            end
        end
    end

    initial begin
        logic [15:0] lfsr;
        done     = 0;
        checks   = 0;
        fails    = 0;
        in_valid = 1;
        in_x     = M'(MASK);
        in_y     = M'(5);
        // R1: inputs active during reset must not reach the outputs
        @(negedge clk);
        @(negedge clk);
        check(out_valid == 0, "R1 reset valid", int'(out_valid), 0);
        check(out_x == 0 && out_y == 0 && out_rot == 0, "R1 reset data",
              int'(out_x) + int'(out_y) + int'(out_rot), 0);
        in_valid = 0;
        wait (!rst);
        @(negedge clk);
        check(out_valid == 0, "R1 first cycle after reset", int'(out_valid), 0);
        live = 1;

        // Full sweep of x, back to back (R3 R4 R8 all hit here).
        for (int x = 0; x <= MASK; x++)
            send(1, x, (x * 37 + 11) & MASK);

        // Gapped stream (R7).
        lfsr = 16'hACE1;
        for (int i = 0; i < 80; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            send(lfsr[0] | lfsr[5], int'(lfsr[15:4]) & MASK, int'(lfsr[11:0]) & MASK);
        end

        send(0, 0, 0);
        for (int i = 0; i < LAT + 4; i++) @(posedge clk);
        // R7: every accepted input produced its result
        check(q.size() == 0, "R7 results outstanding", q.size(), 0);
        live = 0;
        done = 1;
    end
endmodule

module tb_frob_class_min;
    logic clk = 0;
    logic rst = 1;
    logic done_a, done_b;
    int   chk_a, chk_b, bad_a, bad_b;
    int   wd_fail = 0;

    always #5 clk = ~clk;

    // Many ties: compare field narrower than the word.
    tb_frob_lane #(.M(5), .T(3)) lane_a (
        .clk(clk), .rst(rst), .done(done_a), .checks(chk_a), .fails(bad_a)
    );
    // Full-width compare on a prime width.
    tb_frob_lane #(.M(7), .T(7)) lane_b (
        .clk(clk), .rst(rst), .done(done_b), .checks(chk_b), .fails(bad_b)
    );

    initial begin
        repeat (4) @(posedge clk);
        #1 rst = 0;
    end

    initial begin
        int n;
        n = 0;
        while (!(done_a && done_b) && n < 20000) begin
            @(posedge clk);
            n++;
        end
        if (!(done_a && done_b)) begin
            wd_fail = 1;
            $display("FAIL watchdog expired after %0d cycles", n);
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***",
                 chk_a + chk_b + wd_fail, bad_a + bad_b + wd_fail);
        $finish;
    end
endmodule